// File: doc/BRIEF.md
# Directory-Protocol Cache Agent

This block is the coherence engine on the cache side of one site in a directory-based coherence scheme. It holds a small direct-mapped array. Each line has a tag, one data word and one of four states: invalid, shared, owned-and-modified, or pending. Processor loads and stores that hit are served locally. A miss, or a store to a line held only as shared, becomes a request message to the home node. The line then waits in the pending state until the home's grant arrives, and the processor is stalled for that whole time.

The block also answers requests that the home node starts. An invalidate request removes a shared copy. A writeback request returns modified data and keeps the line as shared. A flush request returns the data and drops the line. Messages leave through one outbound valid/ready channel and arrive through one inbound valid/ready channel, and each channel feeds a message FIFO outside the block. Only one processor miss is in flight at a time. A miss that would displace a modified line of another tag first sends that line's data home as a voluntary eviction.

The address splits into an index (the low `IDX_W` bits) and a tag (the remaining bits). Message kinds are 4-bit codes, listed in the requirements.

Top module: `coh_cache_agent`

## Requirements
- R1: After reset every line is invalid, `cpuReqReady` is 1, `outValid` is 0 and `cpuRspValid` is 0.
- R2: A load whose tag matches a line in the shared or modified state is accepted and answered with the line's data on `cpuRspValid`, one cycle after acceptance. No message is sent.
- R3: A load miss sends a read-request message (kind 1) carrying the request address and data 0. The line becomes pending, and `cpuReqReady` stays 0 until the matching grant arrives.
- R4: A store to an invalid line, a shared line, or a line with another tag sends an ownership-request message (kind 2) carrying the request address and data 0.
- R5: A shared grant (kind 3) whose address equals the pending address installs the line as shared with the grant data, and returns that data on `cpuRspValid` one cycle later.
- R6: An ownership grant (kind 4) installs the line as modified. For each byte lane i the result takes the store data where `cpuReqBe[i]` is 1 and the grant data elsewhere. The merged word is returned on `cpuRspValid`.
- R7: A store to a matching modified line merges its enabled bytes into the line and answers with the merged word. No message is sent.
- R8: A home invalidate (kind 5) is answered with an invalidate acknowledgement (kind 8) that has the same address and data 0. A matching shared line becomes invalid, so the next load to it misses.
- R9: A home writeback request (kind 6) is answered with writeback data (kind 9) that carries the line's data. A matching modified line becomes shared, so loads still hit and a store sends kind 2.
- R10: A home flush request (kind 7) is answered with flush data (kind 10) that carries the line's data. A matching modified line becomes invalid.
- R11: A miss whose index holds a modified line of another tag first sends an eviction message (kind 11) with the victim's address and data, and only then sends the request. A shared victim is dropped without a message.
- R12: Home requests are answered while a miss is pending, and the pending miss still completes when its grant arrives.
- R13: While `outReady` is 0, a pending eviction or request message keeps `outValid` at 1 and holds its kind and address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuReqValid | input | 1 | Processor request valid |
| cpuReqReady | output | 1 | Request accepted this cycle when valid |
| cpuReqWrite | input | 1 | 1 = store, 0 = load |
| cpuReqAddr | input | ADDR_W | Request word address |
| cpuReqBe | input | DATA_W/8 | Store byte enables |
| cpuReqData | input | DATA_W | Store data |
| cpuRspValid | output | 1 | One-cycle completion pulse |
| cpuRspData | output | DATA_W | Load data or merged store result |
| outValid | output | 1 | Outbound message valid |
| outReady | input | 1 | Outbound FIFO can accept |
| outKind | output | 4 | Outbound message kind |
| outAddr | output | ADDR_W | Outbound message address |
| outData | output | DATA_W | Outbound message data |
| inValid | input | 1 | Inbound message valid |
| inReady | output | 1 | Inbound message consumed this cycle when valid |
| inKind | input | 4 | Inbound message kind |
| inAddr | input | ADDR_W | Inbound message address |
| inData | input | DATA_W | Inbound message data |

## Verification
The bench targets the following corner cases:

- **Byte merge on an ownership grant.** A design that dropped the store data, or took the grant data for every lane, would return the wrong word.
- **Writeback downgrade.** The later load must still hit while the later store must ask for ownership again. A design that invalidated the line, or kept it modified, would send a message too many or one too few.
- **Modified victim versus shared victim.** A modified victim needs an eviction message ahead of the request and a shared victim needs none. Mixing these up either loses dirty data or adds a spurious message.
- **Home invalidate during a pending miss, and a stalled outbound channel.** The bench checks that the pending miss survives the invalidate and that the request is held steady while the channel is stalled. A design that blocked home traffic while waiting would hang.

// File: rtl/coh_agent_pkg.sv
package coh_agent_pkg;

  typedef enum logic [1:0] {
    LINE_INVALID = 2'd0,
    LINE_SHARED  = 2'd1,
    LINE_OWNED   = 2'd2,
    LINE_PENDING = 2'd3
  } lineState_t;

  typedef enum logic [3:0] {
    MSG_NONE         = 4'd0,
    MSG_GET_SHARED   = 4'd1,
    MSG_GET_OWNED    = 4'd2,
    MSG_GRANT_SHARED = 4'd3,
    MSG_GRANT_OWNED  = 4'd4,
    MSG_HOME_INV     = 4'd5,
    MSG_HOME_WB      = 4'd6,
    MSG_HOME_FLUSH   = 4'd7,
    MSG_INV_ACK      = 4'd8,
    MSG_WB_DATA      = 4'd9,
    MSG_FLUSH_DATA   = 4'd10,
    MSG_EVICT_DATA   = 4'd11
  } msgKind_t;

  typedef struct packed {
    logic latchReq;
    logic rspLoadHit;
    logic storeHit;
    logic setPending;
    logic installShared;
    logic installOwned;
    logic dropLine;
    logic demoteLine;
  } ctlStrobes_t;

endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
  import coh_agent_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       stb,
  input  logic              cpuReqWrite,
  input  logic [ADDR_W-1:0] cpuReqAddr,
  input  logic [DATA_W/8-1:0] cpuReqBe,
  input  logic [DATA_W-1:0] cpuReqData,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [DATA_W-1:0] inData,
  output lineState_t        cpuLineState,
  output logic              cpuTagMatch,
  output lineState_t        inLineState,
  output logic              inTagMatch,
  output logic [DATA_W-1:0] inLineData,
  output logic [ADDR_W-1:0] reqAddr,
  output logic              reqWrite,
  output lineState_t        reqLineState,
  output logic [ADDR_W-1:0] victimAddr,
  output logic [DATA_W-1:0] victimData,
  output logic [DATA_W-1:0] rspData
);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int LINES = 1 << IDX_W;
  localparam int BE_W  = DATA_W / 8;

  lineState_t        stateQ [LINES];
  logic [TAG_W-1:0]  tagQ   [LINES];
  logic [DATA_W-1:0] dataQ  [LINES];

  logic [ADDR_W-1:0] reqAddrQ;
  logic              reqWriteQ;
  logic [DATA_W-1:0] reqDataQ;
  logic [BE_W-1:0]   reqBeQ;
  logic [DATA_W-1:0] rspDataQ;

  function automatic logic [DATA_W-1:0] mergeBytes(input logic [DATA_W-1:0] base,
                                                   input logic [DATA_W-1:0] wr,
                                                   input logic [BE_W-1:0]   be);
    logic [DATA_W-1:0] res;
    res = base;
    for (int b = 0; b < BE_W; b++)
      if (be[b]) res[b*8 +: 8] = wr[b*8 +: 8];
    return res;
  endfunction

  logic [IDX_W-1:0]  cpuIdx, inIdx, reqIdx;
  logic [DATA_W-1:0] storeMerge, ownedMerge;

  assign cpuIdx = cpuReqAddr[IDX_W-1:0];
  assign inIdx  = inAddr[IDX_W-1:0];
  assign reqIdx = reqAddrQ[IDX_W-1:0];

  assign cpuLineState = stateQ[cpuIdx];
  assign cpuTagMatch  = tagQ[cpuIdx] == cpuReqAddr[ADDR_W-1:IDX_W];
  assign inLineState  = stateQ[inIdx];
  assign inTagMatch   = tagQ[inIdx] == inAddr[ADDR_W-1:IDX_W];
  assign inLineData   = dataQ[inIdx];
  assign reqAddr      = reqAddrQ;
  assign reqWrite     = reqWriteQ;
  assign reqLineState = stateQ[reqIdx];
  assign victimAddr   = {tagQ[reqIdx], reqIdx};
  assign victimData   = dataQ[reqIdx];
  assign rspData      = rspDataQ;

  assign storeMerge = mergeBytes(dataQ[cpuIdx], cpuReqData, cpuReqBe);
  assign ownedMerge = mergeBytes(inData, reqDataQ, reqBeQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqAddrQ  <= '0;
      reqWriteQ <= 1'b0;
      reqDataQ  <= '0;
      reqBeQ    <= '0;
    end else if (stb.latchReq) begin
      reqAddrQ  <= cpuReqAddr;
      reqWriteQ <= cpuReqWrite;
      reqDataQ  <= cpuReqData;
      reqBeQ    <= cpuReqWrite ? cpuReqBe : '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < LINES; i++) begin
        stateQ[i] <= LINE_INVALID;
        tagQ[i]   <= '0;
        dataQ[i]  <= '0;
      end
    end else begin
      if (stb.storeHit) dataQ[cpuIdx] <= storeMerge;
      if (stb.setPending) begin
        stateQ[reqIdx] <= LINE_PENDING;
        tagQ[reqIdx]   <= reqAddrQ[ADDR_W-1:IDX_W];
      end
      if (stb.installShared) begin
        stateQ[reqIdx] <= LINE_SHARED;
        dataQ[reqIdx]  <= inData;
      end
      if (stb.installOwned) begin
        stateQ[reqIdx] <= LINE_OWNED;
        dataQ[reqIdx]  <= ownedMerge;
      end
      if (stb.dropLine)   stateQ[inIdx] <= LINE_INVALID;
      if (stb.demoteLine) stateQ[inIdx] <= LINE_SHARED;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  rspDataQ <= '0;
    else if (stb.storeHit)      rspDataQ <= storeMerge;
    else if (stb.rspLoadHit)    rspDataQ <= dataQ[cpuIdx];
    else if (stb.installShared) rspDataQ <= inData;
    else if (stb.installOwned)  rspDataQ <= ownedMerge;
  end

  // R12: control never asks for two array updates in one cycle
  assert_single_update_R12: assert property (@(posedge clk) disable iff (!rstN)
    $countones({stb.storeHit, stb.setPending, stb.installShared, stb.installOwned,
                stb.dropLine, stb.demoteLine}) <= 1);

  // R3: issuing a request leaves the target line pending
  assert_pending_after_issue_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.setPending |=> reqLineState == LINE_PENDING);

endmodule

// File: rtl/coh_agent_ctl.sv
module coh_agent_ctl
  import coh_agent_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReqValid,
  input  logic              cpuReqWrite,
  output logic              cpuReqReady,
  output logic              cpuRspValid,
  input  lineState_t        cpuLineState,
  input  logic              cpuTagMatch,
  input  logic              inValid,
  input  logic [3:0]        inKind,
  input  logic [ADDR_W-1:0] inAddr,
  output logic              inReady,
  input  lineState_t        inLineState,
  input  logic              inTagMatch,
  input  logic [DATA_W-1:0] inLineData,
  input  logic              outReady,
  output logic              outValid,
  output logic [3:0]        outKind,
  output logic [ADDR_W-1:0] outAddr,
  output logic [DATA_W-1:0] outData,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  lineState_t        reqLineState,
  input  logic [ADDR_W-1:0] victimAddr,
  input  logic [DATA_W-1:0] victimData,
  output ctlStrobes_t       stb
);
  typedef enum logic [1:0] {C_IDLE, C_EVICT, C_ISSUE, C_WAIT} ctlState_t;

  ctlState_t stateQ, stateD;
  msgKind_t  kindOut;
  logic      rspSet, homeReq, isGrant, cpuValidLine, inOwned;

  assign outKind = kindOut;
  assign homeReq = inValid && (inKind == MSG_HOME_INV || inKind == MSG_HOME_WB ||
                               inKind == MSG_HOME_FLUSH);
  assign isGrant = inKind == MSG_GRANT_SHARED || inKind == MSG_GRANT_OWNED;
  assign cpuValidLine = cpuTagMatch && (cpuLineState == LINE_SHARED || cpuLineState == LINE_OWNED);
  assign inOwned = inTagMatch && inLineState == LINE_OWNED;

  always_comb begin
    stb         = '0;
    stateD      = stateQ;
    rspSet      = 1'b0;
    cpuReqReady = 1'b0;
    inReady     = 1'b0;
    outValid    = 1'b0;
    kindOut     = MSG_NONE;
    outAddr     = '0;
    outData     = '0;
    if ((stateQ == C_IDLE || stateQ == C_WAIT) && homeReq) begin
      outValid = 1'b1;
      outAddr  = inAddr;
      inReady  = outReady;
      if (inKind == MSG_HOME_INV) begin
        kindOut = MSG_INV_ACK;
        stb.dropLine = outReady && inTagMatch && inLineState == LINE_SHARED;
      end else if (inKind == MSG_HOME_WB) begin
        kindOut = MSG_WB_DATA;
        outData = inLineData;
        stb.demoteLine = outReady && inOwned;
      end else begin
        kindOut = MSG_FLUSH_DATA;
        outData = inLineData;
        stb.dropLine = outReady && inOwned;
      end
    end else if (stateQ == C_IDLE) begin
      if (inValid) begin
        inReady = 1'b1;
      end else begin
        cpuReqReady = 1'b1;
        if (cpuReqValid) begin
          stb.latchReq = 1'b1;
          if (!cpuReqWrite && cpuValidLine) begin
            stb.rspLoadHit = 1'b1;
            rspSet = 1'b1;
          end else if (cpuReqWrite && cpuTagMatch && cpuLineState == LINE_OWNED) begin
            stb.storeHit = 1'b1;
            rspSet = 1'b1;
          end else if (cpuLineState == LINE_OWNED && !cpuTagMatch) begin
            stateD = C_EVICT;
          end else begin
            stateD = C_ISSUE;
          end
        end
      end
    end else if (stateQ == C_EVICT) begin
      outValid = 1'b1;
      kindOut  = MSG_EVICT_DATA;
      outAddr  = victimAddr;
      outData  = victimData;
      if (outReady) stateD = C_ISSUE;
    end else if (stateQ == C_ISSUE) begin
      outValid = 1'b1;
      kindOut  = reqWrite ? MSG_GET_OWNED : MSG_GET_SHARED;
      outAddr  = reqAddr;
      if (outReady) begin
        stb.setPending = 1'b1;
        stateD = C_WAIT;
      end
    end else if (inValid) begin
      inReady = 1'b1;
      if (isGrant && inAddr == reqAddr) begin
        stb.installShared = inKind == MSG_GRANT_SHARED;
        stb.installOwned  = inKind == MSG_GRANT_OWNED;
        rspSet = 1'b1;
        stateD = C_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ      <= C_IDLE;
      cpuRspValid <= 1'b0;
    end else begin
      stateQ      <= stateD;
      cpuRspValid <= rspSet;
    end
  end

  // R3: while waiting for a grant the requested line is pending in the array
  assert_wait_pending_R3: assert property (@(posedge clk) disable iff (!rstN)
    stateQ == C_WAIT |-> reqLineState == LINE_PENDING);

  // R5: a matching grant completes the request one cycle later
  assert_grant_completes_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == C_WAIT && inValid && inReady && isGrant && inAddr == reqAddr)
      |=> (cpuRspValid && stateQ == C_IDLE));

  // R13: a stalled eviction or request message is held
  assert_out_hold_R13: assert property (@(posedge clk) disable iff (!rstN)
    ((stateQ == C_EVICT || stateQ == C_ISSUE) && !outReady)
      |=> (outValid && $stable(outKind) && $stable(outAddr)));

  // R3: the processor sees no completion while a miss is outstanding
  assert_no_rsp_waiting_R3: assert property (@(posedge clk) disable iff (!rstN)
    stateQ == C_WAIT |-> !cpuRspValid);

endmodule

// File: rtl/coh_cache_agent.sv
module coh_cache_agent
  import coh_agent_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cpuReqValid,
  output logic                cpuReqReady,
  input  logic                cpuReqWrite,
  input  logic [ADDR_W-1:0]   cpuReqAddr,
  input  logic [DATA_W/8-1:0] cpuReqBe,
  input  logic [DATA_W-1:0]   cpuReqData,
  output logic                cpuRspValid,
  output logic [DATA_W-1:0]   cpuRspData,
  output logic                outValid,
  input  logic                outReady,
  output logic [3:0]          outKind,
  output logic [ADDR_W-1:0]   outAddr,
  output logic [DATA_W-1:0]   outData,
  input  logic                inValid,
  output logic                inReady,
  input  logic [3:0]          inKind,
  input  logic [ADDR_W-1:0]   inAddr,
  input  logic [DATA_W-1:0]   inData
);
  ctlStrobes_t       stb;
  lineState_t        cpuLineState, inLineState, reqLineState;
  logic              cpuTagMatch, inTagMatch, reqWrite;
  logic [DATA_W-1:0] inLineData, victimData;
  logic [ADDR_W-1:0] reqAddr, victimAddr;

  coh_line_store #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) store_i (
    .clk(clk), .rstN(rstN), .stb(stb),
    .cpuReqWrite(cpuReqWrite), .cpuReqAddr(cpuReqAddr), .cpuReqBe(cpuReqBe),
    .cpuReqData(cpuReqData), .inAddr(inAddr), .inData(inData),
    .cpuLineState(cpuLineState), .cpuTagMatch(cpuTagMatch),
    .inLineState(inLineState), .inTagMatch(inTagMatch), .inLineData(inLineData),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqLineState(reqLineState),
    .victimAddr(victimAddr), .victimData(victimData), .rspData(cpuRspData)
  );

  coh_agent_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ctl_i (
    .clk(clk), .rstN(rstN),
    .cpuReqValid(cpuReqValid), .cpuReqWrite(cpuReqWrite),
    .cpuReqReady(cpuReqReady), .cpuRspValid(cpuRspValid),
    .cpuLineState(cpuLineState), .cpuTagMatch(cpuTagMatch),
    .inValid(inValid), .inKind(inKind), .inAddr(inAddr), .inReady(inReady),
    .inLineState(inLineState), .inTagMatch(inTagMatch), .inLineData(inLineData),
    .outReady(outReady), .outValid(outValid), .outKind(outKind),
    .outAddr(outAddr), .outData(outData),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqLineState(reqLineState),
    .victimAddr(victimAddr), .victimData(victimData), .stb(stb)
  );

endmodule

// File: tb/coh_cache_agent_tb_top.sv
module coh_cache_agent_tb_top;
  localparam int K_GETS = 1, K_GETO = 2, K_GRS = 3, K_GRO = 4, K_HINV = 5,
                 K_HWB = 6, K_HFL = 7, K_IACK = 8, K_WBD = 9, K_FLD = 10, K_EVD = 11;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN, cpuReqValid, cpuReqReady, cpuReqWrite, cpuRspValid;
  logic [7:0]  cpuReqAddr, outAddr, inAddr;
  logic [1:0]  cpuReqBe;
  logic [15:0] cpuReqData, cpuRspData, outData, inData;
  logic        outValid, outReady, inValid, inReady;
  logic [3:0]  outKind, inKind;

  coh_cache_agent dut_i (
    .clk(clk), .rstN(rstN), .cpuReqValid(cpuReqValid), .cpuReqReady(cpuReqReady),
    .cpuReqWrite(cpuReqWrite), .cpuReqAddr(cpuReqAddr), .cpuReqBe(cpuReqBe),
    .cpuReqData(cpuReqData), .cpuRspValid(cpuRspValid), .cpuRspData(cpuRspData),
    .outValid(outValid), .outReady(outReady), .outKind(outKind), .outAddr(outAddr),
    .outData(outData), .inValid(inValid), .inReady(inReady), .inKind(inKind),
    .inAddr(inAddr), .inData(inData)
  );

  int total = 0, bad = 0;
  bit finished = 0;
  logic [27:0] expMsg[$];
  string       expMsgTag[$];
  logic [15:0] expRsp[$];
  string       expRspTag[$];

  task automatic check(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic expectMsg(int kind, int addr, int data, string tag);
    expMsg.push_back({kind[3:0], addr[7:0], data[15:0]});
    expMsgTag.push_back(tag);
  endtask

  task automatic expectRsp(int data, string tag);
    expRsp.push_back(data[15:0]);
    expRspTag.push_back(tag);
  endtask

  // monitor: pops expected items as the design produces them
  logic [27:0] gotMsg, wantMsg;
  logic [15:0] wantRsp;
  string       curTag;
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (outValid && outReady) begin
        gotMsg = {outKind, outAddr, outData};
        if (expMsg.size() == 0) check(0, "R2", "unexpected message", int'(gotMsg), 0);
        else begin
          wantMsg = expMsg.pop_front();
          curTag  = expMsgTag.pop_front();
          check(gotMsg == wantMsg, curTag, "message kind/addr/data", int'(gotMsg), int'(wantMsg));
        end
      end
      if (cpuRspValid) begin
        if (expRsp.size() == 0) check(0, "R2", "unexpected response", int'(cpuRspData), 0);
        else begin
          wantRsp = expRsp.pop_front();
          curTag  = expRspTag.pop_front();
          check(cpuRspData == wantRsp, curTag, "response data", int'(cpuRspData), int'(wantRsp));
        end
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic cpuOp(bit wr, int addr, int be, int data);
    @(posedge clk); #1;
    cpuReqValid = 1'b1; cpuReqWrite = wr; cpuReqAddr = addr[7:0];
    cpuReqBe = be[1:0]; cpuReqData = data[15:0];
    do @(negedge clk); while (!cpuReqReady);
    @(posedge clk); #1;
    cpuReqValid = 1'b0;
  endtask

  task automatic homeMsg(int kind, int addr, int data);
    @(posedge clk); #1;
    inValid = 1'b1; inKind = kind[3:0]; inAddr = addr[7:0]; inData = data[15:0];
    do @(negedge clk); while (!inReady);
    @(posedge clk); #1;
    inValid = 1'b0;
  endtask

  task automatic drain(string tag);
    int guard = 0;
    while ((expMsg.size() != 0 || expRsp.size() != 0) && guard < 50) begin
      @(posedge clk);
      guard++;
    end
    check(expMsg.size() == 0 && expRsp.size() == 0, tag, "outstanding expectations",
          expMsg.size() + expRsp.size(), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R12 watchdog actual=hung expected=done");
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; cpuReqValid = 0; cpuReqWrite = 0; cpuReqAddr = 0; cpuReqBe = 0;
    cpuReqData = 0; outReady = 1; inValid = 0; inKind = 0; inAddr = 0; inData = 0;
    idle(3); #1 rstN = 1'b1;
    @(negedge clk);
    check(cpuReqReady == 1 && outValid == 0 && cpuRspValid == 0, "R1", "reset outputs",
          {cpuReqReady, outValid, cpuRspValid}, 3'b100);

    // R3 load miss on a reset (invalid) line, stall while pending, R5 shared grant
    expectMsg(K_GETS, 8'h10, 0, "R3");
    cpuOp(0, 8'h10, 0, 0);
    idle(3); @(negedge clk);
    check(cpuReqReady == 0, "R3", "stall while pending", cpuReqReady, 0);
    expectRsp(16'h1234, "R5");
    homeMsg(K_GRS, 8'h10, 16'h1234);
    drain("R5");

    // R2 load hit
    expectRsp(16'h1234, "R2");
    cpuOp(0, 8'h10, 0, 0);
    drain("R2");

    // R4 store to shared line, R6 byte merge on ownership grant
    expectMsg(K_GETO, 8'h10, 0, "R4");
    cpuOp(1, 8'h10, 2'b01, 16'hABCD);
    expectRsp(16'h56CD, "R6");
    homeMsg(K_GRO, 8'h10, 16'h5678);
    drain("R6");

    // R7 store hit merges upper byte
    expectRsp(16'hEFCD, "R7");
    cpuOp(1, 8'h10, 2'b10, 16'hEF00);
    drain("R7");

    // R9 writeback downgrade
    expectMsg(K_WBD, 8'h10, 16'hEFCD, "R9");
    homeMsg(K_HWB, 8'h10, 0);
    expectRsp(16'hEFCD, "R9");
    cpuOp(0, 8'h10, 0, 0);
    drain("R9");
    expectMsg(K_GETO, 8'h10, 0, "R9");
    cpuOp(1, 8'h10, 2'b11, 16'h1111);
    expectRsp(16'h1111, "R9");
    homeMsg(K_GRO, 8'h10, 16'hEFCD);
    drain("R9");

    // R10 flush
    expectMsg(K_FLD, 8'h10, 16'h1111, "R10");
    homeMsg(K_HFL, 8'h10, 0);
    expectMsg(K_GETS, 8'h10, 0, "R10");
    cpuOp(0, 8'h10, 0, 0);
    expectRsp(16'h2222, "R10");
    homeMsg(K_GRS, 8'h10, 16'h2222);
    drain("R10");

    // R8 invalidate of a shared line
    expectMsg(K_IACK, 8'h10, 0, "R8");
    homeMsg(K_HINV, 8'h10, 0);
    expectMsg(K_GETS, 8'h10, 0, "R8");
    cpuOp(0, 8'h10, 0, 0);
    expectRsp(16'h3333, "R8");
    homeMsg(K_GRS, 8'h10, 16'h3333);
    drain("R8");

    // R11 modified victim is evicted before the request
    expectMsg(K_GETO, 8'h21, 0, "R4");
    cpuOp(1, 8'h21, 2'b11, 16'h4444);
    expectRsp(16'h4444, "R6");
    homeMsg(K_GRO, 8'h21, 16'h0000);
    drain("R6");
    expectMsg(K_EVD, 8'h21, 16'h4444, "R11");
    expectMsg(K_GETS, 8'h25, 0, "R11");
    cpuOp(0, 8'h25, 0, 0);
    expectRsp(16'h5555, "R11");
    homeMsg(K_GRS, 8'h25, 16'h5555);
    drain("R11");
    // R11 shared victim: no eviction message
    expectMsg(K_GETS, 8'h29, 0, "R11");
    cpuOp(0, 8'h29, 0, 0);
    expectRsp(16'h6666, "R11");
    homeMsg(K_GRS, 8'h29, 16'h6666);
    drain("R11");

    // R12 home invalidate served while a miss is pending
    expectMsg(K_GETS, 8'h02, 0, "R12");
    cpuOp(0, 8'h02, 0, 0);
    expectMsg(K_IACK, 8'h29, 0, "R12");
    homeMsg(K_HINV, 8'h29, 0);
    expectRsp(16'h7777, "R12");
    homeMsg(K_GRS, 8'h02, 16'h7777);
    drain("R12");
    expectMsg(K_GETS, 8'h29, 0, "R12");
    cpuOp(0, 8'h29, 0, 0);
    expectRsp(16'h8888, "R12");
    homeMsg(K_GRS, 8'h29, 16'h8888);
    drain("R12");

    // R13 stalled outbound channel holds the request
    outReady = 1'b0;
    expectMsg(K_GETO, 8'h33, 0, "R13");
    cpuOp(1, 8'h33, 2'b10, 16'h9900);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(outValid == 1 && outKind == 4'(K_GETO) && outAddr == 8'h33, "R13",
            "held request", {outValid, outKind, outAddr}, {1'b1, 4'(K_GETO), 8'h33});
    end
    @(posedge clk); #1 outReady = 1'b1;
    expectRsp(16'h99AA, "R13");
    homeMsg(K_GRO, 8'h33, 16'h00AA);
    drain("R13");

    idle(5);
    check(expMsg.size() == 0 && expRsp.size() == 0, "R2", "no stray outputs", 0, 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule